// File: doc/BRIEF.md
# Completion Queue with Rename Allocation

This block is the in-order bookkeeping core of a small out-of-order back end. Each instruction that dispatch sends to the back end first claims a slot in a six-slot ring, which records program order. In the same step the block hands out rename tags from separate pools: general-purpose, floating-point, and three single-register pools (condition, link and loop counter). Dispatch offers up to two instructions per cycle. The block accepts an in-order prefix of them and returns the slot tag and the rename tags for each instruction it accepts.

Execution units report completion by giving back a slot tag on the finish port. The block then retires up to two of the oldest slots per cycle, and only slots that have finished. Each retirement appears on the retire port as an architectural write-back notice that carries the destination register and rename tags. The rename registers that the retiring instruction held return to their pools at that moment. A flush discards all in-flight work and refills every pool in one cycle. The free counts for slots and for each pool come straight from registers, so dispatch can use them in the same cycle.

Top module: `completion_queue`

## Requirements
- R1: After reset, free_entries equals DEPTH, free_gpr equals NGPR, free_fpr equals NFPR, free_cond, free_link and free_loop are 1, and ret_vld is 0.
- R2: Accepted instructions get slot tags in program order, counting upward modulo DEPTH. Slot 0 of a cycle is older than slot 1. The tags continue from the previous acceptance.
- R3: disp_ack is valid in the same cycle as the request. Slot 1 is accepted only if slot 0 is accepted. Slot 0 needs one free slot, and both slots together need two. The free count of each pool must cover the combined demand of the accepted instructions.
- R4: A general or floating-point destination receives the lowest-numbered free register of its pool. When both slots ask for the same pool, slot 1 receives the next-lowest free register.
- R5: Each special pool (condition, link, loop) holds one register, and only one in-flight instruction may own it. A second request in the same cycle, or any request while the register is owned, is refused.
- R6: A finish report (fin_vld with fin_entry) marks an allocated slot as finished. A report for a slot that is not allocated is ignored: that slot, when allocated later, does not retire before its own finish report.
- R7: Up to two of the oldest slots retire per cycle, strictly in order. An unfinished older slot blocks every younger slot. ret_vld rises the cycle after the clock edge at which the slot leaves the ring. Bit 0 of each ret_* field is the older retirement. Each retirement carries the slot tag, the destination flags, the architectural register index and the rename tags.
- R8: The slot and rename registers that a retiring instruction held count as free from the same edge at which its retirement becomes visible on ret_vld.
- R9: When all DEPTH slots are occupied, free_entries is 0 and disp_ack is 0.
- R10: flush, when high at a clock edge, empties the ring, refills every pool, suppresses retirement, and restarts slot tags at 0. disp_ack is 0 while flush is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all in-flight instructions |
| disp_vld | input | 2 | Dispatch request per slot |
| disp_gpr | input | 2 | Slot writes a general-purpose register |
| disp_fpr | input | 2 | Slot writes a floating-point register |
| disp_cond | input | 2 | Slot writes the condition register |
| disp_link | input | 2 | Slot writes the link register |
| disp_loop | input | 2 | Slot writes the loop counter register |
| disp_areg | input | 2*AREG_W | Architectural destination index per slot |
| disp_ack | output | 2 | Slot accepted this cycle |
| disp_entry | output | 2*EW | Slot tag given to each dispatch slot |
| disp_gtag | output | 2*GW | General rename tag per slot |
| disp_ftag | output | 2*FW | Floating-point rename tag per slot |
| fin_vld | input | 1 | Finish report valid |
| fin_entry | input | EW | Slot tag that finished |
| ret_vld | output | 2 | Retirement valid, bit 0 oldest |
| ret_entry | output | 2*EW | Retired slot tags |
| ret_gpr | output | 2 | Retired instruction wrote a general register |
| ret_fpr | output | 2 | Retired instruction wrote a floating-point register |
| ret_cond | output | 2 | Retired instruction wrote the condition register |
| ret_link | output | 2 | Retired instruction wrote the link register |
| ret_loop | output | 2 | Retired instruction wrote the loop counter |
| ret_areg | output | 2*AREG_W | Architectural destination per retirement |
| ret_gtag | output | 2*GW | General rename tag being written back |
| ret_ftag | output | 2*FW | Floating-point rename tag being written back |
| free_entries | output | ECW | Free ring slots |
| free_gpr | output | GCW | Free general rename registers |
| free_fpr | output | FCW | Free floating-point rename registers |
| free_cond | output | 1 | Condition rename register free |
| free_link | output | 1 | Link rename register free |
| free_loop | output | 1 | Loop counter rename register free |

## Verification
The bench builds the block with its default parameters: six slots, six general and six floating-point rename registers, single special registers and a five-bit register index. With six slots, a handful of paired dispatches reaches tag wrap-around, the full-ring refusal and a two-wide retirement that spans the wrap point. Pools the same size as the ring make lowest-free reuse visible: a naive rotating allocator would return different tags. The one-register special pools expose same-cycle conflicts and the in-order refusal of a younger slot behind a blocked older one.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int unsigned CQ_WAYS  = 2;
  localparam int unsigned CQ_NSPEC = 3;

  typedef struct packed {
    logic gp;
    logic fp;
    logic cond;
    logic link;
    logic loop;
  } dest_kind_t;

  localparam int unsigned CQ_KIND_W = $bits(dest_kind_t);
endpackage

// File: rtl/cq_rename_pool.sv
module cq_rename_pool #(
  parameter int N  = 6,
  parameter int TW = (N > 1) ? $clog2(N) : 1,
  parameter int CW = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic [1:0]      alloc_req,
  output logic [2*TW-1:0] alloc_tag,
  input  logic [1:0]      free_req,
  input  logic [2*TW-1:0] free_tag,
  output logic [CW-1:0]   free_cnt
);
  logic [N-1:0]  avail_q, avail_n;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] first_idx, second_idx;

  function automatic logic [TW-1:0] lowest(input logic [N-1:0] v);
    logic [TW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = TW'(i);
    end
    return r;
  endfunction

  always_comb begin
    first_idx  = lowest(avail_q);
    second_idx = lowest(avail_q & ~(N'(1) << first_idx));
  end

  assign alloc_tag[TW-1:0]    = first_idx;
  assign alloc_tag[2*TW-1:TW] = alloc_req[0] ? second_idx : first_idx;

  always_comb begin
    avail_n = avail_q;
    if (alloc_req[0]) avail_n[alloc_tag[TW-1:0]]    = 1'b0;
    if (alloc_req[1]) avail_n[alloc_tag[2*TW-1:TW]] = 1'b0;
    if (free_req[0])  avail_n[free_tag[TW-1:0]]     = 1'b1;
    if (free_req[1])  avail_n[free_tag[2*TW-1:TW]]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      avail_q <= '1;
      cnt_q   <= CW'(N);
    end else begin
      avail_q <= avail_n;
      cnt_q   <= cnt_q + CW'(free_req[0]) + CW'(free_req[1])
                       - CW'(alloc_req[0]) - CW'(alloc_req[1]);
    end
  end

  assign free_cnt = cnt_q;
endmodule

// File: rtl/cq_single_slot.sv
module cq_single_slot (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic [1:0] take,
  input  logic [1:0] give,
  output logic       avail
);
  logic busy_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      busy_q <= 1'b0;
    end else if (|take) begin
      busy_q <= 1'b1;
    end else if (|give) begin
      busy_q <= 1'b0;
    end
  end

  assign avail = ~busy_q;
endmodule

// File: rtl/cq_dispatch_gate.sv
module cq_dispatch_gate
  import cq_pkg::*;
#(
  parameter int ECW = 3,
  parameter int GCW = 3,
  parameter int FCW = 3
) (
  input  logic                flush,
  input  logic [1:0]          req,
  input  dest_kind_t          kind0,
  input  dest_kind_t          kind1,
  input  logic [ECW-1:0]      free_ent,
  input  logic [GCW-1:0]      free_g,
  input  logic [FCW-1:0]      free_f,
  input  logic [CQ_NSPEC-1:0] spec_avail,
  output logic [1:0]          ack
);
  logic [CQ_NSPEC-1:0] sp0, sp1;
  logic                ok0, ok1, spec_ok0, spec_ok1;

  assign sp0 = {kind0.loop, kind0.link, kind0.cond};
  assign sp1 = {kind1.loop, kind1.link, kind1.cond};

  always_comb begin
    spec_ok0 = 1'b1;
    spec_ok1 = 1'b1;
    for (int s = 0; s < int'(CQ_NSPEC); s++) begin
      if (sp0[s] && !spec_avail[s]) spec_ok0 = 1'b0;
      if (sp1[s] && (!spec_avail[s] || sp0[s])) spec_ok1 = 1'b0;
    end
    ok0 = req[0] && !flush && (int'(free_ent) >= 1) && spec_ok0
          && (int'(kind0.gp) <= int'(free_g))
          && (int'(kind0.fp) <= int'(free_f));
    ok1 = ok0 && req[1] && (int'(free_ent) >= 2) && spec_ok1
          && (int'(kind0.gp) + int'(kind1.gp) <= int'(free_g))
          && (int'(kind0.fp) + int'(kind1.fp) <= int'(free_f));
  end

  assign ack = {ok1, ok0};
endmodule

// File: rtl/cq_entry_ring.sv
module cq_entry_ring #(
  parameter int DEPTH = 6,
  parameter int PW    = 16,
  parameter int EW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [1:0]    wr_en,
  input  logic [EW-1:0] wr_idx0,
  input  logic [EW-1:0] wr_idx1,
  input  logic [PW-1:0] wr_dat0,
  input  logic [PW-1:0] wr_dat1,
  input  logic          fin_vld,
  input  logic [EW-1:0] fin_idx,
  input  logic [1:0]    clr_en,
  input  logic [EW-1:0] rd_idx0,
  input  logic [EW-1:0] rd_idx1,
  output logic [PW-1:0] rd_dat0,
  output logic [PW-1:0] rd_dat1,
  output logic          rd_valid0,
  output logic          rd_valid1,
  output logic          rd_done0,
  output logic          rd_done1
);
  logic [PW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] valid_q, valid_n, done_q, done_n;
  logic             fin_hit;

  always_ff @(posedge clk) begin
    if (wr_en[0]) mem[wr_idx0] <= wr_dat0;
    if (wr_en[1]) mem[wr_idx1] <= wr_dat1;
  end

  assign fin_hit = fin_vld && (int'(fin_idx) < DEPTH) && valid_q[fin_idx];

  always_comb begin
    valid_n = valid_q;
    done_n  = done_q;
    if (clr_en[0]) valid_n[rd_idx0] = 1'b0;
    if (clr_en[1]) valid_n[rd_idx1] = 1'b0;
    if (fin_hit)   done_n[fin_idx]  = 1'b1;
    if (wr_en[0]) begin
      valid_n[wr_idx0] = 1'b1;
      done_n[wr_idx0]  = 1'b0;
    end
    if (wr_en[1]) begin
      valid_n[wr_idx1] = 1'b1;
      done_n[wr_idx1]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_q <= '0;
      done_q  <= '0;
    end else begin
      valid_q <= valid_n;
      done_q  <= done_n;
    end
  end

  assign rd_dat0   = mem[rd_idx0];
  assign rd_dat1   = mem[rd_idx1];
  assign rd_valid0 = valid_q[rd_idx0];
  assign rd_valid1 = valid_q[rd_idx1];
  assign rd_done0  = done_q[rd_idx0];
  assign rd_done1  = done_q[rd_idx1];
endmodule

// File: rtl/completion_queue.sv
module completion_queue
  import cq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int NGPR   = 6,
  parameter int NFPR   = 6,
  parameter int AREG_W = 5,
  localparam int EW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ECW = $clog2(DEPTH + 1),
  localparam int GW  = (NGPR > 1) ? $clog2(NGPR) : 1,
  localparam int GCW = $clog2(NGPR + 1),
  localparam int FW  = (NFPR > 1) ? $clog2(NFPR) : 1,
  localparam int FCW = $clog2(NFPR + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic [1:0]          disp_vld,
  input  logic [1:0]          disp_gpr,
  input  logic [1:0]          disp_fpr,
  input  logic [1:0]          disp_cond,
  input  logic [1:0]          disp_link,
  input  logic [1:0]          disp_loop,
  input  logic [2*AREG_W-1:0] disp_areg,
  output logic [1:0]          disp_ack,
  output logic [2*EW-1:0]     disp_entry,
  output logic [2*GW-1:0]     disp_gtag,
  output logic [2*FW-1:0]     disp_ftag,
  input  logic                fin_vld,
  input  logic [EW-1:0]       fin_entry,
  output logic [1:0]          ret_vld,
  output logic [2*EW-1:0]     ret_entry,
  output logic [1:0]          ret_gpr,
  output logic [1:0]          ret_fpr,
  output logic [1:0]          ret_cond,
  output logic [1:0]          ret_link,
  output logic [1:0]          ret_loop,
  output logic [2*AREG_W-1:0] ret_areg,
  output logic [2*GW-1:0]     ret_gtag,
  output logic [2*FW-1:0]     ret_ftag,
  output logic [ECW-1:0]      free_entries,
  output logic [GCW-1:0]      free_gpr,
  output logic [FCW-1:0]      free_fpr,
  output logic                free_cond,
  output logic                free_link,
  output logic                free_loop
);
  localparam int PW = int'(CQ_KIND_W) + AREG_W + GW + FW;

  function automatic logic [EW-1:0] wrap_inc(input logic [EW-1:0] p);
    return (p == EW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // ring pointers and occupancy
  logic [EW-1:0]  head_q, tail_q, head_n, tail_n, tail_p1, head_p1;
  logic [ECW-1:0] count_q;

  // dispatch side
  dest_kind_t          dk0, dk1;
  logic [1:0]          ack;
  logic [2*GW-1:0]     g_tag;
  logic [2*FW-1:0]     f_tag;
  logic [CQ_NSPEC-1:0] spec_avail;
  logic [PW-1:0]       wdat0, wdat1;

  // retire side
  logic [PW-1:0]   rdat0, rdat1;
  logic            rv0, rv1, rdn0, rdn1, r0, r1;
  dest_kind_t      rk0, rk1;
  logic [AREG_W-1:0] ra0, ra1;
  logic [GW-1:0]   rg0, rg1;
  logic [FW-1:0]   rf0, rf1;

  assign dk0 = '{gp: disp_gpr[0], fp: disp_fpr[0], cond: disp_cond[0],
                 link: disp_link[0], loop: disp_loop[0]};
  assign dk1 = '{gp: disp_gpr[1], fp: disp_fpr[1], cond: disp_cond[1],
                 link: disp_link[1], loop: disp_loop[1]};

  assign free_entries = ECW'(DEPTH) - count_q;
  assign tail_p1      = wrap_inc(tail_q);
  assign head_p1      = wrap_inc(head_q);

  cq_dispatch_gate #(.ECW(ECW), .GCW(GCW), .FCW(FCW)) u_gate (
    .flush      (flush),
    .req        (disp_vld),
    .kind0      (dk0),
    .kind1      (dk1),
    .free_ent   (free_entries),
    .free_g     (free_gpr),
    .free_f     (free_fpr),
    .spec_avail (spec_avail),
    .ack        (ack)
  );

  assign disp_ack   = ack;
  assign disp_entry = {tail_p1, tail_q};
  assign disp_gtag  = g_tag;
  assign disp_ftag  = f_tag;

  // unpack retiring payloads
  assign {rk0, ra0, rg0, rf0} = rdat0;
  assign {rk1, ra1, rg1, rf1} = rdat1;

  assign r0 = rv0 && rdn0 && !flush;
  assign r1 = r0 && rv1 && rdn1;

  cq_rename_pool #(.N(NGPR), .TW(GW), .CW(GCW)) u_gpool (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .alloc_req ({ack[1] & dk1.gp, ack[0] & dk0.gp}),
    .alloc_tag (g_tag),
    .free_req  ({r1 & rk1.gp, r0 & rk0.gp}),
    .free_tag  ({rg1, rg0}),
    .free_cnt  (free_gpr)
  );

  cq_rename_pool #(.N(NFPR), .TW(FW), .CW(FCW)) u_fpool (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .alloc_req ({ack[1] & dk1.fp, ack[0] & dk0.fp}),
    .alloc_tag (f_tag),
    .free_req  ({r1 & rk1.fp, r0 & rk0.fp}),
    .free_tag  ({rf1, rf0}),
    .free_cnt  (free_fpr)
  );

  // special registers: index 0 condition, 1 link, 2 loop
  logic [CQ_NSPEC-1:0] sp_d0, sp_d1, sp_r0, sp_r1;
  assign sp_d0 = {dk0.loop, dk0.link, dk0.cond};
  assign sp_d1 = {dk1.loop, dk1.link, dk1.cond};
  assign sp_r0 = {rk0.loop, rk0.link, rk0.cond};
  assign sp_r1 = {rk1.loop, rk1.link, rk1.cond};

  for (genvar s = 0; s < int'(CQ_NSPEC); s++) begin : g_spec
    cq_single_slot u_slot (
      .clk   (clk),
      .rst   (rst),
      .flush (flush),
      .take  ({ack[1] & sp_d1[s], ack[0] & sp_d0[s]}),
      .give  ({r1 & sp_r1[s], r0 & sp_r0[s]}),
      .avail (spec_avail[s])
    );
  end

  assign free_cond = spec_avail[0];
  assign free_link = spec_avail[1];
  assign free_loop = spec_avail[2];

  assign wdat0 = {dk0, disp_areg[AREG_W-1:0], g_tag[GW-1:0], f_tag[FW-1:0]};
  assign wdat1 = {dk1, disp_areg[2*AREG_W-1:AREG_W], g_tag[2*GW-1:GW],
                  f_tag[2*FW-1:FW]};

  cq_entry_ring #(.DEPTH(DEPTH), .PW(PW), .EW(EW)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .wr_en     (ack),
    .wr_idx0   (tail_q),
    .wr_idx1   (tail_p1),
    .wr_dat0   (wdat0),
    .wr_dat1   (wdat1),
    .fin_vld   (fin_vld),
    .fin_idx   (fin_entry),
    .clr_en    ({r1, r0}),
    .rd_idx0   (head_q),
    .rd_idx1   (head_p1),
    .rd_dat0   (rdat0),
    .rd_dat1   (rdat1),
    .rd_valid0 (rv0),
    .rd_valid1 (rv1),
    .rd_done0  (rdn0),
    .rd_done1  (rdn1)
  );

  always_comb begin
    head_n = r1 ? wrap_inc(head_p1) : (r0 ? head_p1 : head_q);
    tail_n = ack[1] ? wrap_inc(tail_p1) : (ack[0] ? tail_p1 : tail_q);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_n;
      tail_q  <= tail_n;
      count_q <= count_q + ECW'(ack[0]) + ECW'(ack[1])
                         - ECW'(r0) - ECW'(r1);
    end
  end

  // registered write-back notices
  always_ff @(posedge clk) begin
    if (rst) begin
      ret_vld   <= '0;
      ret_entry <= '0;
      ret_gpr   <= '0;
      ret_fpr   <= '0;
      ret_cond  <= '0;
      ret_link  <= '0;
      ret_loop  <= '0;
      ret_areg  <= '0;
      ret_gtag  <= '0;
      ret_ftag  <= '0;
    end else begin
      ret_vld   <= {r1, r0};
      ret_entry <= {head_p1, head_q};
      ret_gpr   <= {rk1.gp, rk0.gp};
      ret_fpr   <= {rk1.fp, rk0.fp};
      ret_cond  <= {rk1.cond, rk0.cond};
      ret_link  <= {rk1.link, rk0.link};
      ret_loop  <= {rk1.loop, rk0.loop};
      ret_areg  <= {ra1, ra0};
      ret_gtag  <= {rg1, rg0};
      ret_ftag  <= {rf1, rf0};
    end
  end
endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
  parameter int DEPTH = 6,
  parameter int NGPR  = 6,
  parameter int NFPR  = 6,
  parameter int EW    = 3,
  parameter int ECW   = 3,
  parameter int GCW   = 3,
  parameter int FCW   = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           flush,
  input logic [1:0]     disp_ack,
  input logic [1:0]     disp_cond,
  input logic [1:0]     ret_vld,
  input logic [2*EW-1:0] ret_entry,
  input logic [ECW-1:0] free_entries,
  input logic [GCW-1:0] free_gpr,
  input logic [FCW-1:0] free_fpr
);
  function automatic logic [EW-1:0] nxt(input logic [EW-1:0] p);
    return (p == EW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    int'(free_entries) <= DEPTH);

  a_r3_pair_needs_room: assert property (@(posedge clk) disable iff (rst)
    disp_ack[1] |-> int'(free_entries) >= 2);

  a_r7_older_first: assert property (@(posedge clk) disable iff (rst)
    ret_vld[1] |-> ret_vld[0]);

  a_r7_consecutive: assert property (@(posedge clk) disable iff (rst)
    ret_vld[1] |-> ret_entry[2*EW-1:EW] == nxt(ret_entry[EW-1:0]));

  a_r10_flush_refills: assert property (@(posedge clk) disable iff (rst)
    flush |=> (int'(free_entries) == DEPTH && int'(free_gpr) == NGPR
               && int'(free_fpr) == NFPR && ret_vld == 2'b00));

  a_r5_single_cond: assert property (@(posedge clk) disable iff (rst)
    disp_ack == 2'b11 |-> disp_cond != 2'b11);

  a_r8_pool_bounded: assert property (@(posedge clk) disable iff (rst)
    int'(free_gpr) <= NGPR && int'(free_fpr) <= NFPR);
endmodule

bind completion_queue cq_checker #(
  .DEPTH(DEPTH), .NGPR(NGPR), .NFPR(NFPR),
  .EW(EW), .ECW(ECW), .GCW(GCW), .FCW(FCW)
) u_cq_chk (
  .clk          (clk),
  .rst          (rst),
  .flush        (flush),
  .disp_ack     (disp_ack),
  .disp_cond    (disp_cond),
  .ret_vld      (ret_vld),
  .ret_entry    (ret_entry),
  .free_entries (free_entries),
  .free_gpr     (free_gpr),
  .free_fpr     (free_fpr)
);

// File: tb/tb_completion_queue.sv
`timescale 1ns/1ps
module tb_completion_queue;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic [1:0]  disp_vld = '0, disp_gpr = '0, disp_fpr = '0;
  logic [1:0]  disp_cond = '0, disp_link = '0, disp_loop = '0;
  logic [9:0]  disp_areg = '0;
  logic [1:0]  disp_ack;
  logic [5:0]  disp_entry, disp_gtag, disp_ftag;
  logic        fin_vld = 1'b0;
  logic [2:0]  fin_entry = '0;
  logic [1:0]  ret_vld, ret_gpr, ret_fpr, ret_cond, ret_link, ret_loop;
  logic [5:0]  ret_entry, ret_gtag, ret_ftag;
  logic [9:0]  ret_areg;
  logic [2:0]  free_entries, free_gpr, free_fpr;
  logic        free_cond, free_link, free_loop;

  int n_chk = 0;
  int n_bad = 0;
  bit done_run = 1'b0;

  always #2.5 clk = ~clk;

  completion_queue dut (
    .clk(clk), .rst(rst), .flush(flush),
    .disp_vld(disp_vld), .disp_gpr(disp_gpr), .disp_fpr(disp_fpr),
    .disp_cond(disp_cond), .disp_link(disp_link), .disp_loop(disp_loop),
    .disp_areg(disp_areg), .disp_ack(disp_ack), .disp_entry(disp_entry),
    .disp_gtag(disp_gtag), .disp_ftag(disp_ftag),
    .fin_vld(fin_vld), .fin_entry(fin_entry),
    .ret_vld(ret_vld), .ret_entry(ret_entry), .ret_gpr(ret_gpr),
    .ret_fpr(ret_fpr), .ret_cond(ret_cond), .ret_link(ret_link),
    .ret_loop(ret_loop), .ret_areg(ret_areg), .ret_gtag(ret_gtag),
    .ret_ftag(ret_ftag), .free_entries(free_entries), .free_gpr(free_gpr),
    .free_fpr(free_fpr), .free_cond(free_cond), .free_link(free_link),
    .free_loop(free_loop)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drv(input int s, input bit g, input bit f, input bit c,
                     input bit l, input bit p, input int a);
    disp_vld[s]  = 1'b1;
    disp_gpr[s]  = g;
    disp_fpr[s]  = f;
    disp_cond[s] = c;
    disp_link[s] = l;
    disp_loop[s] = p;
    disp_areg[s*5 +: 5] = a[4:0];
  endtask

  task automatic idle();
    disp_vld = '0; disp_gpr = '0; disp_fpr = '0;
    disp_cond = '0; disp_link = '0; disp_loop = '0; disp_areg = '0;
    fin_vld = 1'b0; flush = 1'b0;
  endtask

  task automatic fin(input int e);
    fin_vld = 1'b1;
    fin_entry = e[2:0];
    step();
    fin_vld = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "free_entries", free_entries, 6);
    chk("R1", "free_gpr", free_gpr, 6);
    chk("R1", "free_fpr", free_fpr, 6);
    chk("R1", "free specials", {free_cond, free_link, free_loop}, 7);
    chk("R1", "ret_vld", ret_vld, 0);
  endtask

  task automatic t_pair();
    drv(0, 1, 0, 0, 0, 0, 3);
    drv(1, 1, 1, 0, 0, 0, 7);
    #1;
    chk("R3", "ack pair", disp_ack, 3);
    chk("R2", "entry0", disp_entry[2:0], 0);
    chk("R2", "entry1", disp_entry[5:3], 1);
    chk("R4", "gtag0", disp_gtag[2:0], 0);
    chk("R4", "gtag1", disp_gtag[5:3], 1);
    chk("R4", "ftag1", disp_ftag[5:3], 0);
    step(); idle();
    chk("R3", "free_entries after pair", free_entries, 4);
    chk("R4", "free_gpr after pair", free_gpr, 4);
    chk("R4", "free_fpr after pair", free_fpr, 5);
  endtask

  task automatic t_in_order();
    fin(1);
    step();
    chk("R7", "younger blocked", ret_vld, 0);
    chk("R7", "entries held", free_entries, 4);
    fin(0);
    step();
    chk("R7", "two retire", ret_vld, 3);
    chk("R7", "ret entry0", ret_entry[2:0], 0);
    chk("R7", "ret entry1", ret_entry[5:3], 1);
    chk("R7", "ret gpr", ret_gpr, 3);
    chk("R7", "ret fpr", ret_fpr, 2);
    chk("R7", "ret areg0", ret_areg[4:0], 3);
    chk("R7", "ret areg1", ret_areg[9:5], 7);
    chk("R7", "ret gtag1", ret_gtag[5:3], 1);
    chk("R8", "free_gpr back", free_gpr, 6);
    chk("R8", "free_fpr back", free_fpr, 6);
    chk("R8", "free_entries back", free_entries, 6);
    step();
    chk("R7", "pulse ends", ret_vld, 0);
  endtask

  task automatic t_lowest_wrap();
    drv(0, 1, 0, 0, 0, 0, 1);
    drv(1, 1, 0, 0, 0, 0, 2);
    #1;
    chk("R2", "entry continues", disp_entry[2:0], 2);
    step(); idle();
    drv(0, 1, 0, 0, 0, 0, 4);
    #1;
    chk("R4", "third gtag", disp_gtag[2:0], 2);
    step(); idle();
    fin(2); fin(3); step(); step();
    chk("R8", "free_gpr partial", free_gpr, 5);
    drv(0, 1, 0, 0, 0, 0, 5);
    drv(1, 1, 0, 0, 0, 0, 6);
    #1;
    chk("R4", "reuse lowest", disp_gtag[2:0], 0);
    chk("R4", "reuse next", disp_gtag[5:3], 1);
    chk("R2", "wrap entry0", disp_entry[2:0], 5);
    chk("R2", "wrap entry1", disp_entry[5:3], 0);
    step(); idle();
    fin(5); fin(0); fin(4);
    step();
    chk("R7", "wrap retire pair", ret_vld, 3);
    chk("R7", "wrap entries", ret_entry, {3'd5, 3'd4});
    step();
    chk("R7", "wrap retire last", ret_vld, 1);
    chk("R7", "wrap last entry", ret_entry[2:0], 0);
    chk("R8", "free_gpr wrapped", free_gpr, 6);
  endtask

  task automatic t_special();
    drv(0, 0, 0, 1, 1, 0, 0);
    drv(1, 0, 0, 1, 0, 0, 0);
    #1;
    chk("R5", "second cond refused", disp_ack, 1);
    step(); idle();
    chk("R5", "cond link taken", {free_cond, free_link, free_loop}, 1);
    drv(0, 0, 0, 1, 0, 0, 0);
    drv(1, 0, 0, 0, 0, 0, 0);
    #1;
    chk("R3", "blocked older stops younger", disp_ack, 0);
    idle();
    drv(0, 0, 0, 0, 0, 1, 0);
    drv(1, 0, 0, 0, 1, 0, 0);
    #1;
    chk("R5", "link busy", disp_ack, 1);
    step(); idle();
    chk("R5", "loop taken", free_loop, 0);
    fin(1); fin(2); step(); step();
    chk("R8", "specials back", {free_cond, free_link, free_loop}, 7);
    chk("R8", "entries back", free_entries, 6);
  endtask

  task automatic t_full_flush();
    drv(0, 1, 1, 1, 0, 0, 9);
    step(); idle();
    drv(0, 0, 0, 0, 0, 0, 0); drv(1, 0, 0, 0, 0, 0, 0);
    step();
    step(); idle();
    chk("R9", "one left", free_entries, 1);
    drv(0, 0, 0, 0, 0, 0, 0); drv(1, 0, 0, 0, 0, 0, 0);
    #1;
    chk("R3", "room for one", disp_ack, 1);
    step(); idle();
    chk("R9", "full count", free_entries, 0);
    drv(0, 0, 0, 0, 0, 0, 0);
    #1;
    chk("R9", "full refuses", disp_ack, 0);
    idle();
    flush = 1'b1;
    drv(0, 0, 0, 0, 0, 0, 0);
    #1;
    chk("R10", "ack during flush", disp_ack, 0);
    step(); idle();
    chk("R10", "entries refilled", free_entries, 6);
    chk("R10", "gpr refilled", free_gpr, 6);
    chk("R10", "cond refilled", free_cond, 1);
    chk("R10", "no retire", ret_vld, 0);
    drv(0, 1, 0, 0, 0, 0, 2);
    #1;
    chk("R10", "tag restarts", disp_entry[2:0], 0);
    chk("R10", "gtag restarts", disp_gtag[2:0], 0);
    step(); idle();
  endtask

  task automatic t_stray_finish();
    fin(3);
    step();
    chk("R6", "stray no retire", ret_vld, 0);
    chk("R6", "entries unchanged", free_entries, 5);
    drv(0, 0, 0, 0, 0, 0, 0); drv(1, 0, 0, 0, 0, 0, 0);
    step(); idle();
    drv(0, 0, 0, 0, 0, 0, 0);
    #1;
    chk("R2", "slot three", disp_entry[2:0], 3);
    step(); idle();
    fin(0); fin(1); fin(2);
    step();
    chk("R6", "last finished retires", ret_vld, 1);
    chk("R6", "entry two", ret_entry[2:0], 2);
    step();
    chk("R6", "stray slot waits", ret_vld, 0);
    chk("R6", "slot three held", free_entries, 5);
    fin(3);
    step();
    chk("R6", "own finish retires", ret_vld, 1);
    chk("R6", "entry three", ret_entry[2:0], 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pair();
    t_in_order();
    t_lowest_wrap();
    t_special();
    t_full_flush();
    t_stray_finish();
    done_run = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_run) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule